// File: doc/BRIEF.md
# Port Control Register Pair with Mode-Entry Triggers

This block holds the data and configuration registers of one general-purpose I/O port on an 8-bit controller. A CPU writes and reads them over a small register bus: `bus_sel` picks the register, a pulse on `bus_wr` stores `bus_wdata`, and `bus_rdata` always shows the selected register. The low six bits of the data register drive the port's output values. The low six bits of the configuration register drive the port's output enables.

The two top bit positions do not control pins, because one of those pins is input-only and the other carries the clock output or serves as a clock-option input. In the data register they are write-only triggers. Writing 1 to bit 7 asks the power sequencer to stop the clock. Writing 1 to bit 6 asks it to enter the low-power idle state. Both bits read back as 0.

In the configuration register, bit 6 makes the serial shifter use the alternate phase of its shift clock. Bit 7 enables a start-up delay after halt. That delay enable reaches its output only when the RC clock option is in use.

A three-state machine turns the trigger writes into single-cycle request pulses:
- **ST_RUN**: the rest state. No request is active.
- **ST_HALT_REQ**: drives `halt_req` for one cycle.
- **ST_IDLE_REQ**: drives `idle_req` for one cycle.

The transitions are:
- **T_HALT**: any state goes to ST_HALT_REQ on a data write with bit 7 set.
- **T_IDLE**: any state goes to ST_IDLE_REQ on a data write with bit 6 set and bit 7 clear.
- **T_DONE**: any state returns to ST_RUN when neither trigger is written.

Top module: `port_ctl_regs`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both registers. After reset, `pin_out`, `pin_dir`, `halt_req`, `idle_req`, `sk_alt_phase`, `clk_dly_en` are 0, and both registers read 0x00.
- R2: A write with `bus_sel`=0 stores `bus_wdata[5:0]` in the data register. From the next clock edge that value appears on `pin_out` and in `bus_rdata[5:0]`.
- R3: A write with `bus_sel`=1 stores all 8 bits in the configuration register. From the next edge, bits 5:0 appear on `pin_dir`, and `bus_rdata` returns the full byte.
- R4: A data write with bit 7 = 1 makes `halt_req` high for exactly the one cycle after the write edge (state ST_HALT_REQ), unless that bit is written again.
- R5: A data write with bit 6 = 1 and bit 7 = 0 makes `idle_req` high for exactly the one cycle after the write edge (state ST_IDLE_REQ).
- R6: A data write with bits 7 and 6 both 1 raises only `halt_req`. Halt has priority, and `halt_req` and `idle_req` are never high together.
- R7: With `bus_sel`=0, `bus_rdata[7:6]` read 0, whatever was written there.
- R8: `sk_alt_phase` equals configuration bit 6.
- R9: `clk_dly_en` equals configuration bit 7 AND `rc_mode`.
- R10: A configuration write never raises a request and never changes `pin_out`. A data write never changes `pin_dir`, `sk_alt_phase` or `clk_dly_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 1 | Register select: 0 data, 1 configuration |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| rc_mode | input | 1 | High when the RC clock option is in use |
| pin_out | output | 6 | Output values for port pins 0–5 |
| pin_dir | output | 6 | Output enables for port pins 0–5 |
| halt_req | output | 1 | One-cycle request to enter halt |
| idle_req | output | 1 | One-cycle request to enter idle |
| sk_alt_phase | output | 1 | Selects the alternate serial-clock phase |
| clk_dly_en | output | 1 | Enables the start-up delay after halt |

## Verification
The bench builds the block with its default width of 8, so the two trigger and control positions sit at bits 7 and 6 and the pin field is six bits wide. At that width, a handful of byte patterns covers every case:
- each trigger alone, both triggers together and back-to-back triggers;
- readback that masks the top data bits;
- the `rc_mode` gating of the delay enable;
- cross-register isolation, with all-ones and alternating patterns on the pin fields.

// File: rtl/port_ctl_pkg.sv
package port_ctl_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HALT_REQ = 2'd1,
        ST_IDLE_REQ = 2'd2
    } req_state_t;

    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_CFG  = 1'b1;
endpackage

// File: rtl/port_ctl_reg.sv
module port_ctl_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/port_ctl_req_fsm.sv
module port_ctl_req_fsm
    import port_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_halt,
    input  logic trig_idle,
    output logic halt_req,
    output logic idle_req
);
    req_state_t state_q, state_d;

    always_comb begin
        if (trig_halt)
            state_d = ST_HALT_REQ;
        else if (trig_idle)
            state_d = ST_IDLE_REQ;
        else
            state_d = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        halt_req = 1'b0;
        idle_req = 1'b0;
        unique case (state_q)
            ST_RUN:      ;
            ST_HALT_REQ: halt_req = 1'b1;
            ST_IDLE_REQ: idle_req = 1'b1;
            default:     ;
        endcase
    end

    // R4
    halt_cause_chk: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> $past(trig_halt));

    // R5
    idle_cause_chk: assert property (@(posedge clk) disable iff (rst)
        idle_req |-> ($past(trig_idle) && !$past(trig_halt)));

    // R6
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({halt_req, idle_req}));
endmodule

// File: rtl/port_ctl_regs.sv
module port_ctl_regs
    import port_ctl_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic              rc_mode,
    output logic [PORT_W-3:0] pin_out,
    output logic [PORT_W-3:0] pin_dir,
    output logic              halt_req,
    output logic              idle_req,
    output logic              sk_alt_phase,
    output logic              clk_dly_en
);
    localparam int PIN_W   = PORT_W - 2;
    localparam int TOP_BIT = PORT_W - 1;
    localparam int SUB_BIT = PORT_W - 2;

    logic              data_we, cfg_we;
    logic [PIN_W-1:0]  data_q;
    logic [PORT_W-1:0] cfg_q;

    assign data_we = bus_wr && (bus_sel == SEL_DATA);
    assign cfg_we  = bus_wr && (bus_sel == SEL_CFG);

    port_ctl_reg #(.W(PIN_W)) u_data (
        .clk (clk),
        .rst (rst),
        .we  (data_we),
        .d   (bus_wdata[PIN_W-1:0]),
        .q   (data_q)
    );

    port_ctl_reg #(.W(PORT_W)) u_cfg (
        .clk (clk),
        .rst (rst),
        .we  (cfg_we),
        .d   (bus_wdata),
        .q   (cfg_q)
    );

    port_ctl_req_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .trig_halt (data_we && bus_wdata[TOP_BIT]),
        .trig_idle (data_we && bus_wdata[SUB_BIT]),
        .halt_req  (halt_req),
        .idle_req  (idle_req)
    );

    assign pin_out      = data_q;
    assign pin_dir      = cfg_q[PIN_W-1:0];
    assign sk_alt_phase = cfg_q[SUB_BIT];
    assign clk_dly_en   = cfg_q[TOP_BIT] && rc_mode;

    always_comb begin
        if (bus_sel == SEL_CFG)
            bus_rdata = cfg_q;
        else
            bus_rdata = {2'b00, data_q};
    end

    // R9
    dly_gate_chk: assert property (@(posedge clk) disable iff (rst)
        clk_dly_en |-> rc_mode);

    // R10
    cfg_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (!halt_req && !idle_req && $stable(pin_out)));

    // R10
    data_write_keeps_dir_chk: assert property (@(posedge clk) disable iff (rst)
        data_we |=> ($stable(pin_dir) && $stable(sk_alt_phase)));
endmodule

// File: tb/port_ctl_regs_test.sv
module port_ctl_regs_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rc_mode = 1'b0;
    logic [5:0] pin_out, pin_dir;
    logic       halt_req, idle_req, sk_alt_phase, clk_dly_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    port_ctl_regs uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rc_mode(rc_mode),
        .pin_out(pin_out), .pin_dir(pin_dir), .halt_req(halt_req),
        .idle_req(idle_req), .sk_alt_phase(sk_alt_phase), .clk_dly_en(clk_dly_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] val);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = val;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        bus_sel = sel;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 pin_out", {2'b0, pin_out}, 8'h00);
        chk("R1 pin_dir", {2'b0, pin_dir}, 8'h00);
        chk("R1 requests", {6'b0, halt_req, idle_req}, 8'h00);
        chk("R1 cfg outs", {6'b0, sk_alt_phase, clk_dly_en}, 8'h00);
        rd(1'b0, v); chk("R1 data read", v, 8'h00);
        rd(1'b1, v); chk("R1 cfg read", v, 8'h00);
    endtask

    task automatic t_data_pins;
        logic [7:0] v;
        wr_reg(1'b0, 8'h2A);
        chk("R2 pin_out 2A", {2'b0, pin_out}, 8'h2A);
        rd(1'b0, v); chk("R2 read 2A", v, 8'h2A);
        wr_reg(1'b0, 8'h15);
        chk("R2 pin_out 15", {2'b0, pin_out}, 8'h15);
        chk("R10 pin_dir untouched", {2'b0, pin_dir}, 8'h00);
    endtask

    task automatic t_cfg;
        logic [7:0] v;
        wr_reg(1'b1, 8'h7F);
        chk("R3 pin_dir", {2'b0, pin_dir}, 8'h3F);
        rd(1'b1, v); chk("R3 cfg read", v, 8'h7F);
        chk("R8 alt phase", {7'b0, sk_alt_phase}, 8'h01);
        chk("R10 cfg write no request", {6'b0, halt_req, idle_req}, 8'h00);
        chk("R10 pin_out kept", {2'b0, pin_out}, 8'h15);
        wr_reg(1'b1, 8'h80);
        chk("R8 alt phase clear", {7'b0, sk_alt_phase}, 8'h00);
        chk("R9 rc_mode low", {7'b0, clk_dly_en}, 8'h00);
        rc_mode = 1'b1; #0.5;
        chk("R9 rc_mode high", {7'b0, clk_dly_en}, 8'h01);
        rc_mode = 1'b0; #0.5;
        chk("R9 rc_mode dropped", {7'b0, clk_dly_en}, 8'h00);
    endtask

    task automatic t_halt;
        logic [7:0] v;
        wr_reg(1'b0, 8'h83);
        chk("R4 halt pulse", {6'b0, halt_req, idle_req}, 8'h02);
        chk("R2 low bits with trigger", {2'b0, pin_out}, 8'h03);
        rd(1'b0, v); chk("R7 top bits read 0", v, 8'h03);
        @(negedge clk);
        chk("R4 halt cleared", {6'b0, halt_req, idle_req}, 8'h00);
        chk("R10 dir kept", {2'b0, pin_dir}, 8'h00);
    endtask

    task automatic t_idle;
        wr_reg(1'b0, 8'h40);
        chk("R5 idle pulse", {6'b0, halt_req, idle_req}, 8'h01);
        @(negedge clk);
        chk("R5 idle cleared", {6'b0, halt_req, idle_req}, 8'h00);
    endtask

    task automatic t_both;
        logic [7:0] v;
        wr_reg(1'b0, 8'hFF);
        chk("R6 halt wins", {6'b0, halt_req, idle_req}, 8'h02);
        rd(1'b0, v); chk("R7 read after FF", v, 8'h3F);
        @(negedge clk);
        chk("R6 cleared", {6'b0, halt_req, idle_req}, 8'h00);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = 8'h80;
        @(negedge clk);
        chk("R4 first halt", {6'b0, halt_req, idle_req}, 8'h02);
        bus_wdata = 8'h40;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R5 idle after halt", {6'b0, halt_req, idle_req}, 8'h01);
        @(negedge clk);
        chk("R5 back to run", {6'b0, halt_req, idle_req}, 8'h00);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected <= 5000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_data_pins();
        t_cfg();
        t_halt();
        t_idle();
        t_both();
        t_back_to_back();
        t_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule